// File: doc/BRIEF.md
# Synchronous Memory Snooze Controller

This block decides when a synchronous memory may drop into its low-power snooze state and when it may take accesses again. A snooze request arrives on a pin with no timing relation to the clock. It is resynchronised and then drives a four-state controller (awake, entering, snoozing, leaving). The controller raises a snooze indication that the power-gating logic uses, and it drops the access enable that qualifies chip selects and address strobes into the core. Entry and exit each take a fixed, parameterised number of cycles. The exit cycles also act as the recovery window, during which no access may begin.

Any access still in flight when entry begins loses its enable and is dropped. Selects or strobes that arrive while the access enable is low are ignored. A protocol-error flag records them. The controller keeps no array state, so the stored contents are never touched. While in reset, and whenever the pin is held low, the block stays awake.

Top module: `snooze_ctrl`

## Requirements
- R1: In reset and on the first cycle after it, sleep_active_o is 0, access_en_o is 1 and proto_err_o is 0.
- R2: The request pin passes through SYNC_STAGES (default 2) flops. A request first driven before clock edge 1 can change the controller state no earlier than edge SYNC_STAGES+1.
- R3: Once the synchronised request is seen, the controller spends ENTRY_CYC (default 2) cycles entering with access_en_o low, and then raises sleep_active_o for as long as the request stays high.
- R4: After the synchronised request falls, the controller spends EXIT_CYC (default 2) cycles leaving with both outputs low, and then returns to awake (access_en_o 1).
- R5: If the synchronised request falls while entering, the controller goes straight to leaving, and sleep_active_o never rises.
- R6: If the synchronised request rises while leaving, the controller goes back to entering and restarts the entry count, and access_en_o stays low.
- R7: access_en_o is 1 only when awake, and is never 1 together with sleep_active_o. access_go_o is 1 when access_en_o is 1, every bit of ce_act_i is 1 and at least one bit of stb_act_i is 1.
- R8: If any bit of ce_act_i or stb_act_i is 1 while access_en_o is 0, proto_err_o is 1 on the next cycle and access_go_o stays 0. With ERR_STICKY=0 (default) the flag lasts one cycle for each offending cycle.
- R9: Activity on ce_act_i or stb_act_i while access_en_o is 1 leaves proto_err_o at 0 on the next cycle (ERR_STICKY=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_pin_i | input | 1 | Asynchronous snooze request, 1 = snooze |
| ce_act_i | input | NUM_CE | Chip selects, 1 = selected |
| stb_act_i | input | NUM_STB | Address strobes, 1 = strobe |
| sleep_active_o | output | 1 | Snooze state reached |
| access_en_o | output | 1 | Core may accept accesses |
| access_go_o | output | 1 | Qualified access start |
| proto_err_o | output | 1 | Select or strobe seen while accesses are blocked |

## Verification
Two paths are hardest to reach from the ports: the request turning back mid-transition, and an access landing inside the recovery window. Both depend on the request edge reaching the controller on an exact cycle after the synchroniser delay. The bench sweeps request pulse widths from one cycle up to well beyond the entry time. For each width it predicts every cycle's outputs with a closed-form function of the width and the latencies. Separate runs toggle the pin low and then high one cycle apart to force a reversal while leaving. They also fire selects a known number of cycles after release, so that the access lands inside the recovery window.

// File: rtl/snz_pkg.sv
package snz_pkg;
   typedef enum logic [1:0] {
      ST_AWAKE = 2'd0,
      ST_ENTER = 2'd1,
      ST_SLEEP = 2'd2,
      ST_EXIT  = 2'd3
   } snz_state_t;
endpackage

// File: rtl/snz_sync.sv
module snz_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/snz_fsm.sv
module snz_fsm
   import snz_pkg::*;
#(
   parameter int ENTRY_CYC = 2,
   parameter int EXIT_CYC  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   output snz_state_t state_o
);
   localparam int MAXC  = (ENTRY_CYC > EXIT_CYC) ? ENTRY_CYC : EXIT_CYC;
   localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
   localparam logic [CNT_W-1:0] EXIT_LAST  = CNT_W'(EXIT_CYC - 1);

   snz_state_t       state, state_nx;
   logic [CNT_W-1:0] cnt, cnt_nx;

   always_comb begin
      state_nx = state;
      cnt_nx   = cnt;
      unique case (state)
         ST_AWAKE: if (req_i) begin
            state_nx = ST_ENTER;
            cnt_nx   = '0;
         end
         ST_ENTER: begin
            if (!req_i) begin
               state_nx = ST_EXIT;
               cnt_nx   = '0;
            end else if (cnt == ENTRY_LAST) begin
               state_nx = ST_SLEEP;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         ST_SLEEP: if (!req_i) begin
            state_nx = ST_EXIT;
            cnt_nx   = '0;
         end
         ST_EXIT: begin
            if (req_i) begin
               state_nx = ST_ENTER;
               cnt_nx   = '0;
            end else if (cnt == EXIT_LAST) begin
               state_nx = ST_AWAKE;
            end else begin
               cnt_nx = cnt + 1'b1;
            end
         end
         default: begin
            state_nx = ST_AWAKE;
            cnt_nx   = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_AWAKE;
         cnt   <= '0;
      end else begin
         state <= state_nx;
         cnt   <= cnt_nx;
      end
   end

   assign state_o = state;
endmodule

// File: rtl/snz_guard.sv
module snz_guard
   import snz_pkg::*;
#(
   parameter int NUM_CE     = 3,
   parameter int NUM_STB    = 2,
   parameter bit ERR_STICKY = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  snz_state_t         state_i,
   input  logic [NUM_CE-1:0]  ce_i,
   input  logic [NUM_STB-1:0] stb_i,
   output logic               access_en_o,
   output logic               access_go_o,
   output logic               err_o
);
   logic any_hit;
   logic violate;
   logic err_q;

   assign access_en_o = (state_i == ST_AWAKE);
   assign any_hit     = (|ce_i) | (|stb_i);
   assign violate     = !access_en_o && any_hit;
   assign access_go_o = access_en_o && (&ce_i) && (|stb_i);

   generate
      if (ERR_STICKY) begin : g_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= err_q | violate;
         end
      end else begin : g_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= violate;
         end
      end
   endgenerate

   assign err_o = err_q;
endmodule

// File: rtl/snooze_ctrl.sv
module snooze_ctrl
   import snz_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ENTRY_CYC   = 2,
   parameter int EXIT_CYC    = 2,
   parameter int NUM_CE      = 3,
   parameter int NUM_STB     = 2,
   parameter bit ERR_STICKY  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sleep_pin_i,
   input  logic [NUM_CE-1:0]  ce_act_i,
   input  logic [NUM_STB-1:0] stb_act_i,
   output logic               sleep_active_o,
   output logic               access_en_o,
   output logic               access_go_o,
   output logic               proto_err_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("snooze_ctrl: SYNC_STAGES must be at least 2");
      end
      if (ENTRY_CYC < 1 || EXIT_CYC < 1) begin : g_bad_lat
         $error("snooze_ctrl: ENTRY_CYC and EXIT_CYC must be at least 1");
      end
      if (NUM_CE < 1 || NUM_STB < 1) begin : g_bad_width
         $error("snooze_ctrl: NUM_CE and NUM_STB must be at least 1");
      end
   endgenerate

   logic       req_sync;
   snz_state_t state;

   snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sleep_pin_i),
      .q_o   (req_sync)
   );

   snz_fsm #(.ENTRY_CYC(ENTRY_CYC), .EXIT_CYC(EXIT_CYC)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_sync),
      .state_o (state)
   );

   snz_guard #(.NUM_CE(NUM_CE), .NUM_STB(NUM_STB), .ERR_STICKY(ERR_STICKY)) u_guard (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .ce_i        (ce_act_i),
      .stb_i       (stb_act_i),
      .access_en_o (access_en_o),
      .access_go_o (access_go_o),
      .err_o       (proto_err_o)
   );

   assign sleep_active_o = (state == ST_SLEEP);
endmodule

// File: rtl/snooze_ctrl_chk.sv
module snooze_ctrl_chk
   import snz_pkg::*;
#(
   parameter int NUM_CE     = 3,
   parameter int NUM_STB    = 2,
   parameter bit ERR_STICKY = 1'b0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_sync,
   input snz_state_t         state,
   input logic [NUM_CE-1:0]  ce_act_i,
   input logic [NUM_STB-1:0] stb_act_i,
   input logic               sleep_active_o,
   input logic               access_en_o,
   input logic               access_go_o,
   input logic               proto_err_o
);
   always_comb begin
      if (rst_n) begin
         assert_exclusive_R7: assert (!(sleep_active_o && access_en_o))
            else $error("access enable and snooze both high");
      end
   end

   assert_sleep_after_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleep_active_o) |-> $past(state) == ST_ENTER);

   assert_wake_after_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(access_en_o) |-> $past(state) == ST_EXIT);

   assert_abort_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ENTER && !req_sync) |=> state == ST_EXIT);

   assert_reenter_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXIT && req_sync) |=> state == ST_ENTER);

   assert_err_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!access_en_o && ((|ce_act_i) || (|stb_act_i))) |=> proto_err_o);

   assert_no_go_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !access_en_o |-> !access_go_o);

   generate
      if (!ERR_STICKY) begin : g_pulse_chk
         assert_no_err_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
            access_en_o |=> !proto_err_o);
      end
   endgenerate
endmodule

bind snooze_ctrl snooze_ctrl_chk #(
   .NUM_CE(NUM_CE), .NUM_STB(NUM_STB), .ERR_STICKY(ERR_STICKY)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_sync       (req_sync),
   .state          (state),
   .ce_act_i       (ce_act_i),
   .stb_act_i      (stb_act_i),
   .sleep_active_o (sleep_active_o),
   .access_en_o    (access_en_o),
   .access_go_o    (access_go_o),
   .proto_err_o    (proto_err_o)
);

// File: tb/snooze_ctrl_tb.sv
module snooze_ctrl_tb;
   localparam int S     = 2;
   localparam int ENTRY = 2;
   localparam int EXIT  = 2;
   localparam int NCE   = 3;
   localparam int NSTB  = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            pin = 1'b0;
   logic [NCE-1:0]  ce = '0;
   logic [NSTB-1:0] stb = '0;
   logic            sleep_act, acc_en, acc_go, perr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   snooze_ctrl #(
      .SYNC_STAGES(S), .ENTRY_CYC(ENTRY), .EXIT_CYC(EXIT),
      .NUM_CE(NCE), .NUM_STB(NSTB), .ERR_STICKY(1'b0)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_pin_i(pin),
      .ce_act_i(ce), .stb_act_i(stb),
      .sleep_active_o(sleep_act), .access_en_o(acc_en),
      .access_go_o(acc_go), .proto_err_o(perr)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // expected state after edge n for a pulse of L edges: 0 awake,1 enter,2 sleep,3 exit
   function automatic int exp_st(input int n, input int L);
      if (n <= S) return 0;
      if (n > L + S + EXIT) return 0;
      if (n > L + S) return 3;
      if (n <= S + ENTRY) return 1;
      return 2;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset sleep", sleep_act, 1'b0);
      chk("R1 reset en", acc_en, 1'b1);
      chk("R1 reset err", perr, 1'b0);
      rst_n = 1'b1;
      tick();
      chk("R1 post-reset en", acc_en, 1'b1);
      chk("R1 post-reset sleep", sleep_act, 1'b0);

      // R2 R3 R4 R5: pulse width sweep
      for (int L = 1; L <= 10; L++) begin
         pin = 1'b1;
         for (int n = 1; n <= L + S + EXIT + 3; n++) begin
            tick();
            begin
               int st;
               st = exp_st(n, L);
               if (n <= S + 1)
                  chk($sformatf("R2 L=%0d n=%0d en", L, n), acc_en, (st == 0));
               else if (st == 3 || n > L + S + EXIT)
                  chk($sformatf("R4 L=%0d n=%0d en", L, n), acc_en, (st == 0));
               else if (L < ENTRY + 1)
                  chk($sformatf("R5 L=%0d n=%0d en", L, n), acc_en, (st == 0));
               else
                  chk($sformatf("R3 L=%0d n=%0d en", L, n), acc_en, (st == 0));
               if (L <= ENTRY)
                  chk($sformatf("R5 L=%0d n=%0d sleep", L, n), sleep_act, 1'b0);
               else
                  chk($sformatf("R3 L=%0d n=%0d sleep", L, n), sleep_act, (st == 2));
            end
            if (n == L) pin = 1'b0;
         end
      end

      // R6: request rises again while leaving
      pin = 1'b1;
      tick();
      pin = 1'b0;
      tick();
      pin = 1'b1;
      for (int n = 3; n <= 7; n++) begin
         tick();
         if (n >= 3) chk($sformatf("R6 n=%0d en", n), acc_en, 1'b0);
         chk($sformatf("R6 n=%0d sleep", n), sleep_act, (n == 7));
      end
      pin = 1'b0;
      repeat (8) tick();
      chk("R4 back awake", acc_en, 1'b1);

      // R7 R9: access while awake
      ce = '1; stb = 2'b01;
      #0;
      @(negedge clk);
      chk("R7 go awake", acc_go, 1'b1);
      ce = 3'b101;
      #1;
      chk("R7 go partial ce", acc_go, 1'b0);
      ce = '1; stb = '0;
      #1;
      chk("R7 go no strobe", acc_go, 1'b0);
      tick();
      chk("R9 no err awake", perr, 1'b0);
      ce = '0; stb = '0;

      // R8: access while snoozing
      pin = 1'b1;
      repeat (8) tick();
      chk("R7 sleep reached", sleep_act, 1'b1);
      chk("R7 en low in sleep", acc_en, 1'b0);
      ce = '1; stb = 2'b10;
      #1;
      chk("R8 go blocked sleep", acc_go, 1'b0);
      tick();
      chk("R8 err after sleep access", perr, 1'b1);
      ce = '0; stb = '0;
      tick();
      chk("R8 err pulse clears", perr, 1'b0);
      ce = 3'b010;
      tick();
      chk("R8 err from ce only", perr, 1'b1);
      ce = '0;
      tick();

      // R8: access inside recovery window
      pin = 1'b0;
      repeat (S + 1) tick();
      chk("R4 leaving en low", acc_en, 1'b0);
      chk("R4 leaving sleep low", sleep_act, 1'b0);
      stb = 2'b01;
      tick();
      chk("R8 err in recovery", perr, 1'b1);
      stb = '0;
      repeat (4) tick();
      chk("R4 awake after recovery", acc_en, 1'b1);
      chk("R9 err clear awake", perr, 1'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule